// File: doc/BRIEF.md
# Peripheral Bus Slave Interface

This block sits on a feature card and answers an asynchronous peripheral bus on which every transfer is paced by strobes. The master drives an address, a read/write line, a card select, two byte-lane strobes and an active-low address strobe. The card runs on its own clock. It passes the strobes through a two-flop synchronizer and then decodes a window of four 16-bit registers. For a read it drives the data bus; for a write it captures the data bus. In both cases it completes the transfer by pulling an active-low data acknowledge low, and it holds that acknowledge until the master takes the address strobe away.

Two of the registers shape the card's behaviour on the bus. A control register switches the port between 16-bit and 8-bit width, and the width is reported on a size output. An interrupt register raises an active-low interrupt request. While an interrupt is pending, the system board can run an interrupt-acknowledge cycle. The card answers that cycle with the same data acknowledge, places a fixed vector on the low data byte, and drops its request. The data bus is split into an input, an output and an output enable, so that the pad ring can build the tri-state driver.

Top module: `pbs_slave`

## Requirements
- R1: After reset, `dtack_n_o` is 1, `data_oe_o` is 0, `size8_o` is 0 and `irq_n_o` is 1, and every storage register reads 0.
- R2: The card acknowledges a bus cycle only when `sel_n_i` is low and address bits 21..3 equal `BASE_ADDR[21..3]`. Any other cycle gets no acknowledge and no driven data. Address bits 2..1 select the register: 0 and 1 are scratch registers, 2 is control and 3 is interrupt.
- R3: Address bits 23 and 22 are reserved and must both be 0. If either is 1, there is no acknowledge.
- R4: `dtack_n_o` first goes low on the third rising clock edge after the strobes are asserted, and never earlier.
- R5: `dtack_n_o` stays low while the address strobe or the interrupt acknowledge is held low. It returns high, together with `data_oe_o` going low, on the third rising edge after both have been released.
- R6: In 16-bit mode, a read (`rw_i` = 1) drives the full register word on `data_o` with `data_oe_o` = 1. A write (`rw_i` = 0) never enables the output.
- R7: In 16-bit mode, a write updates bits 15..8 only when `lane_n_i[0]` is low and bits 7..0 only when `lane_n_i[1]` is low. A write with neither lane strobe asserted changes nothing but is still acknowledged.
- R8: Write data is taken on the edge where the acknowledge asserts. Changing `data_i` afterwards has no effect.
- R9: Bit 0 of the control register selects 8-bit mode and appears on `size8_o`. In 8-bit mode, data uses bits 7..0 only. Address bit 0 chooses the register byte (0 means bits 15..8, 1 means bits 7..0). A read returns that byte with bits 15..8 driven 0. A write with either lane strobe asserted updates that byte from `data_i[7:0]`.
- R10: Writing the interrupt register sets the pending flag from bit 0 of the write data. `irq_n_o` is the inverse of the pending flag, and a read of the register returns the flag in bit 0 with the other bits 0.
- R11: While the pending flag is set, holding `iack_n_i` low produces an acknowledge with `IRQ_VECTOR` on bits 7..0 and 0 on bits 15..8, and clears the pending flag. While the flag is clear, `iack_n_i` gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 24 | Bus address, stable while the address strobe is low |
| data_i | input | 16 | Bus data in from the pad |
| data_o | output | 16 | Bus data out to the pad |
| data_oe_o | output | 1 | Output enable for the data pad drivers |
| as_n_i | input | 1 | Address strobe, active low |
| sel_n_i | input | 1 | Card select, active low |
| rw_i | input | 1 | 1 means read, 0 means write |
| lane_n_i | input | 2 | Byte-lane strobes, active low; [0] covers bits 15..8, [1] covers bits 7..0 |
| iack_n_i | input | 1 | Interrupt acknowledge from the system board, active low |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| size8_o | output | 1 | 0 means 16-bit port, 1 means 8-bit port |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions check the handshake timing on every cycle. The acknowledge never asserts sooner than the synchronizer latency allows, never asserts without the card selected or an interrupt acknowledge present, stays asserted while a strobe is still held, and the data drivers are never enabled outside an acknowledge. The assertions cannot see register contents. These are left to the bench's scenarios: byte-lane masking, the 8-bit byte steering, the timing of the write-data capture, rejection of reserved and out-of-window addresses, and the vector returned on an interrupt acknowledge.

// File: rtl/pbs_pkg.sv
// Package: shared constants and types for the peripheral bus slave.
// Assumes a 16-bit data bus split into two byte lanes.
package pbs_pkg;
    localparam int BUS_DATA_W = 16;
    localparam int BUS_ADDR_W = 24;

    // Handshake state of the slave
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_IACK = 2'd2
    } pbs_state_t;

    // Byte-lane write enables
    typedef struct packed {
        logic hi;
        logic lo;
    } pbs_lane_t;
endpackage

// File: rtl/pbs_sync.sv
// Module: two-flop synchronizer for a group of asynchronous bus inputs.
// Assumes each bit is independent; RESET_VAL is the idle (negated) level.
module pbs_sync #(
    parameter int          WIDTH     = 6,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two metastability-hardening stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RESET_VAL;
            stage2_q <= RESET_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/pbs_decode.sv
// Module: address window decoder.
// Assumes the address is stable while the strobe is asserted. The top two
// address bits are reserved and must be zero; the window holds 2**IDX_W words.
module pbs_decode #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 2,
    parameter logic [ADDR_W-3:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              byte_sel_o
);
    localparam int LOW_W = IDX_W + 1;

    logic reserved_ok;
    logic window_ok;

    // Reserved bits must be zero, upper address must match the base
    always_comb begin
        reserved_ok = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b00);
        window_ok   = (addr_i[ADDR_W-3:LOW_W] == BASE_ADDR[ADDR_W-3:LOW_W]);
        hit_o       = reserved_ok && window_ok;
    end

    assign idx_o      = addr_i[LOW_W-1:1];
    assign byte_sel_o = addr_i[0];
endmodule

// File: rtl/pbs_regs.sv
// Module: register file of the slave with byte write enables.
// Assumes at most one write per bus cycle; the interrupt register holds a
// single pending flag, the control register's bit 0 selects 8-bit mode.
module pbs_regs
    import pbs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 2,
    parameter int CTRL_IDX = 2,
    parameter int IRQ_IDX  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  pbs_lane_t         wr_lane_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              iack_clr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_word_o,
    output logic              narrow_o,
    output logic              pending_o
);
    localparam int NREGS  = 1 << IDX_W;
    localparam int BYTE_W = DATA_W / 2;

    logic [NREGS*DATA_W-1:0] words;
    logic                    pending_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == IRQ_IDX) begin : g_irq
            // Pending flag: set or cleared by a write, cleared by interrupt acknowledge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pending_q <= 1'b0;
                end else if (wr_en_i && wr_idx_i == IDX_W'(g) && wr_lane_i.lo) begin
                    pending_q <= wr_data_i[0];
                end else if (iack_clr_i) begin
                    pending_q <= 1'b0;
                end
            end
            assign words[g*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, pending_q};
        end else begin : g_store
            logic [DATA_W-1:0] q;
            // Storage word with independent upper and lower byte enables
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                    if (wr_lane_i.hi) q[DATA_W-1:BYTE_W] <= wr_data_i[DATA_W-1:BYTE_W];
                    if (wr_lane_i.lo) q[BYTE_W-1:0]      <= wr_data_i[BYTE_W-1:0];
                end
            end
            assign words[g*DATA_W +: DATA_W] = q;
        end
    end

    assign rd_word_o = words[rd_idx_i*DATA_W +: DATA_W];
    assign narrow_o  = words[CTRL_IDX*DATA_W];
    assign pending_o = pending_q;
endmodule

// File: rtl/pbs_ctrl.sv
// Module: handshake controller of the slave.
// Starts a transfer on a synchronized strobe plus address hit, or an
// interrupt acknowledge when a request is pending; holds the acknowledge
// until every strobe is released. Raw address and data are assumed stable
// while the strobes are asserted.
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter logic [7:0] IRQ_VECTOR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n_i,
    input  logic              sel_n_i,
    input  logic              rw_i,
    input  logic [1:0]        lane_n_i,
    input  logic              iack_n_i,
    input  logic              hit_i,
    input  logic              byte_sel_i,
    input  logic              narrow_i,
    input  logic              pending_i,
    input  logic [DATA_W-1:0] rd_word_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              dtack_n_o,
    output logic              data_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_en_o,
    output pbs_lane_t         wr_lane_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              iack_clr_o
);
    localparam int BYTE_W = DATA_W / 2;

    pbs_state_t        state_q;
    logic              start_iack;
    logic              start_xfer;
    logic              release_all;
    logic              any_lane;
    logic [DATA_W-1:0] rd_sel;

    // Start and end conditions of a bus cycle
    always_comb begin
        start_iack  = (state_q == S_IDLE) && !iack_n_i && pending_i;
        start_xfer  = (state_q == S_IDLE) && !start_iack && !as_n_i && !sel_n_i && hit_i;
        release_all = as_n_i && iack_n_i;
        any_lane    = !lane_n_i[0] || !lane_n_i[1];
    end

    // Write strobes and data steering for 16-bit and 8-bit modes
    always_comb begin
        wr_en_o = start_xfer && !rw_i;
        if (narrow_i) begin
            wr_lane_o.hi = any_lane && !byte_sel_i;
            wr_lane_o.lo = any_lane && byte_sel_i;
            wr_data_o    = {bus_data_i[BYTE_W-1:0], bus_data_i[BYTE_W-1:0]};
        end else begin
            wr_lane_o.hi = !lane_n_i[0];
            wr_lane_o.lo = !lane_n_i[1];
            wr_data_o    = bus_data_i;
        end
        iack_clr_o = start_iack;
    end

    // Read data steering: 8-bit mode returns one byte on the low lane
    always_comb begin
        if (narrow_i) begin
            rd_sel = {{BYTE_W{1'b0}},
                      byte_sel_i ? rd_word_i[BYTE_W-1:0] : rd_word_i[DATA_W-1:BYTE_W]};
        end else begin
            rd_sel = rd_word_i;
        end
    end

    // Handshake state, acknowledge, output enable and read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            dtack_n_o <= 1'b1;
            data_oe_o <= 1'b0;
            data_o    <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start_iack) begin
                        state_q   <= S_IACK;
                        dtack_n_o <= 1'b0;
                        data_oe_o <= 1'b1;
                        data_o    <= {{(DATA_W-8){1'b0}}, IRQ_VECTOR};
                    end else if (start_xfer) begin
                        state_q   <= S_XFER;
                        dtack_n_o <= 1'b0;
                        data_oe_o <= rw_i;
                        data_o    <= rw_i ? rd_sel : '0;
                    end
                end
                S_XFER, S_IACK: begin
                    if (release_all) begin
                        state_q   <= S_IDLE;
                        dtack_n_o <= 1'b1;
                        data_oe_o <= 1'b0;
                    end
                end
                default: begin
                    state_q   <= S_IDLE;
                    dtack_n_o <= 1'b1;
                    data_oe_o <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pbs_slave.sv
// Module: top of the peripheral bus slave.
// Synchronizes the bus strobes, decodes the register window, runs the
// handshake and holds the register file. The data pad is split into
// input, output and output enable for a tri-state driver outside.
module pbs_slave
    import pbs_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int IDX_W  = 2,
    parameter logic [ADDR_W-3:0] BASE_ADDR  = 22'h012340,
    parameter logic [7:0]        IRQ_VECTOR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    input  logic              as_n_i,
    input  logic              sel_n_i,
    input  logic              rw_i,
    input  logic [1:0]        lane_n_i,
    input  logic              iack_n_i,
    output logic              dtack_n_o,
    output logic              size8_o,
    output logic              irq_n_o
);
    localparam int SYNC_W   = 6;
    localparam int CTRL_IDX = 2;
    localparam int IRQ_IDX  = 3;

    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic              as_s_n, sel_s_n, rw_s, iack_s_n;
    logic [1:0]        lane_s_n;
    logic              hit, byte_sel, narrow, pending, wr_en, iack_clr;
    logic [IDX_W-1:0]  idx;
    pbs_lane_t         wr_lane;
    logic [DATA_W-1:0] wr_data, rd_word;

    assign sync_in = {as_n_i, sel_n_i, rw_i, lane_n_i, iack_n_i};
    assign {as_s_n, sel_s_n, rw_s, lane_s_n, iack_s_n} = sync_out;

    pbs_sync #(.WIDTH(SYNC_W), .RESET_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    pbs_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr_i     (addr_i),
        .hit_o      (hit),
        .idx_o      (idx),
        .byte_sel_o (byte_sel)
    );

    pbs_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .IRQ_IDX(IRQ_IDX)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (idx),
        .wr_lane_i  (wr_lane),
        .wr_data_i  (wr_data),
        .iack_clr_i (iack_clr),
        .rd_idx_i   (idx),
        .rd_word_o  (rd_word),
        .narrow_o   (narrow),
        .pending_o  (pending)
    );

    pbs_ctrl #(.DATA_W(DATA_W), .IRQ_VECTOR(IRQ_VECTOR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_n_i     (as_s_n),
        .sel_n_i    (sel_s_n),
        .rw_i       (rw_s),
        .lane_n_i   (lane_s_n),
        .iack_n_i   (iack_s_n),
        .hit_i      (hit),
        .byte_sel_i (byte_sel),
        .narrow_i   (narrow),
        .pending_i  (pending),
        .rd_word_i  (rd_word),
        .bus_data_i (data_i),
        .dtack_n_o  (dtack_n_o),
        .data_oe_o  (data_oe_o),
        .data_o     (data_o),
        .wr_en_o    (wr_en),
        .wr_lane_o  (wr_lane),
        .wr_data_o  (wr_data),
        .iack_clr_o (iack_clr)
    );

    assign size8_o = narrow;
    assign irq_n_o = !pending;
endmodule

// File: rtl/pbs_slave_chk.sv
// Module: handshake checker bound to the slave top.
// Assumes the two-flop synchronizer latency of the design; all checks
// are written against the raw bus inputs and the acknowledge outputs.
module pbs_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n_i,
    input logic sel_n_i,
    input logic iack_n_i,
    input logic dtack_n_o,
    input logic data_oe_o
);
    // R4: acknowledge may only fall after a strobe has passed the synchronizer
    assert_ack_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> (!$past(as_n_i, 3) || !$past(iack_n_i, 3)));

    // R2: a data acknowledge needs the card select or an interrupt acknowledge
    assert_ack_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> (!$past(sel_n_i, 3) || !$past(iack_n_i, 3)));

    // R5: acknowledge is held while a strobe is still asserted
    assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n_o && (!$past(as_n_i, 2) || !$past(iack_n_i, 2))) |=> !dtack_n_o);

    // R6: data drivers are enabled only inside an acknowledged cycle
    assert_oe_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !dtack_n_o);

    // R5: drivers are off once the acknowledge has been released
    assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_n_o) |-> !data_oe_o);
endmodule

bind pbs_slave pbs_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n_i    (as_n_i),
    .sel_n_i   (sel_n_i),
    .iack_n_i  (iack_n_i),
    .dtack_n_o (dtack_n_o),
    .data_oe_o (data_oe_o)
);

// File: tb/pbs_slave_tb_top.sv
// Bench: vector table walked by one loop, then directed scenarios.
module pbs_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VEC = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        data_oe;
    logic        as_n = 1'b1;
    logic        sel_n = 1'b1;
    logic        rw = 1'b1;
    logic [1:0]  lane_n = 2'b11;
    logic        iack_n = 1'b1;
    logic        dtack_n;
    logic        size8;
    logic        irq_n;

    int checks = 0;
    int fails = 0;
    int rel_lat = 0;
    logic rel_oe = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbs_slave #(.BASE_ADDR(22'h012340), .IRQ_VECTOR(VEC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .data_i    (data_i),
        .data_o    (data_o),
        .data_oe_o (data_oe),
        .as_n_i    (as_n),
        .sel_n_i   (sel_n),
        .rw_i      (rw),
        .lane_n_i  (lane_n),
        .iack_n_i  (iack_n),
        .dtack_n_o (dtack_n),
        .size8_o   (size8),
        .irq_n_o   (irq_n)
    );

    typedef struct packed {
        logic        rd;
        logic [23:0] a;
        logic [1:0]  ln;
        logic [15:0] wd;
        logic        ack;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h012340, 2'b00, 16'hA5C3, 1'b1, 16'h0000},
        '{1'b1, 24'h012340, 2'b00, 16'h0000, 1'b1, 16'hA5C3},
        '{1'b0, 24'h012342, 2'b10, 16'h1234, 1'b1, 16'h0000},
        '{1'b1, 24'h012342, 2'b00, 16'h0000, 1'b1, 16'h1200},
        '{1'b0, 24'h012342, 2'b01, 16'hFF56, 1'b1, 16'h0000},
        '{1'b1, 24'h012342, 2'b00, 16'h0000, 1'b1, 16'h1256},
        '{1'b0, 24'h012340, 2'b11, 16'h0000, 1'b1, 16'h0000},
        '{1'b1, 24'h012340, 2'b00, 16'h0000, 1'b1, 16'hA5C3},
        '{1'b1, 24'h412340, 2'b00, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 24'h012348, 2'b00, 16'hBEEF, 1'b0, 16'h0000},
        '{1'b1, 24'h012348, 2'b00, 16'h0000, 1'b0, 16'h0000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R6 full-word write/read";
            2, 3:    return "R7 upper lane only";
            4, 5:    return "R7 lower lane only";
            6, 7:    return "R7 no lane, R8 latch";
            8:       return "R3 reserved bit 22";
            default: return "R2 outside window";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One strobe cycle; data_i is changed after the acknowledge (R8)
    task automatic bus_cycle(input logic rd, input logic [23:0] a, input logic [1:0] ln,
                             input logic [15:0] wd, input logic sel,
                             output logic ack, output logic [15:0] rdat, output int lat);
        @(negedge clk);
        addr = a; rw = rd; lane_n = ln; data_i = wd; sel_n = !sel; as_n = 1'b0;
        ack = 1'b0; rdat = '0; lat = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (!ack && !dtack_n) begin
                ack = 1'b1; lat = i;
                if (data_oe) rdat = data_o;
            end
        end
        data_i = ~wd;
        @(negedge clk);
        as_n = 1'b1; sel_n = 1'b1; lane_n = 2'b11;
        rel_lat = 0; rel_oe = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (rel_lat == 0 && dtack_n) begin
                rel_lat = i; rel_oe = data_oe;
            end
        end
    endtask

    task automatic iack_cycle(output logic ack, output logic [15:0] rdat);
        @(negedge clk);
        iack_n = 1'b0; ack = 1'b0; rdat = '0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (!ack && !dtack_n) begin
                ack = 1'b1;
                if (data_oe) rdat = data_o;
            end
        end
        iack_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic        ack;
        logic [15:0] rdat;
        int          lat;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 dtack_n", 32'(dtack_n), 32'd1);
        check("R1 data_oe", 32'(data_oe), 32'd0);
        check("R1 size8", 32'(size8), 32'd0);
        check("R1 irq_n", 32'(irq_n), 32'd1);
        bus_cycle(1'b1, 24'h012342, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R1 reg1 after reset", 32'(rdat), 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i].rd, VECS[i].a, VECS[i].ln, VECS[i].wd, 1'b1, ack, rdat, lat);
            check(vec_tag(i), 32'(ack), 32'(VECS[i].ack));
            if (VECS[i].rd || !VECS[i].ack)
                check({vec_tag(i), " data"}, 32'(rdat), 32'(VECS[i].exp));
        end

        // R4 / R5: acknowledge latency and release timing
        bus_cycle(1'b1, 24'h012340, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R4 ack latency", 32'(lat), 32'd3);
        check("R5 release latency", 32'(rel_lat), 32'd3);
        check("R5 oe off at release", 32'(rel_oe), 32'd0);

        // R2: select not asserted
        bus_cycle(1'b1, 24'h012340, 2'b00, 16'h0, 1'b0, ack, rdat, lat);
        check("R2 no select no ack", 32'(ack), 32'd0);

        // R9: 8-bit mode
        bus_cycle(1'b0, 24'h012344, 2'b00, 16'h0001, 1'b1, ack, rdat, lat);
        check("R9 size8 high", 32'(size8), 32'd1);
        bus_cycle(1'b1, 24'h012340, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R9 narrow read upper byte", 32'(rdat), 32'h00A5);
        bus_cycle(1'b1, 24'h012341, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R9 narrow read lower byte", 32'(rdat), 32'h00C3);
        bus_cycle(1'b0, 24'h012341, 2'b01, 16'h997E, 1'b1, ack, rdat, lat);
        bus_cycle(1'b0, 24'h012345, 2'b01, 16'hFF00, 1'b1, ack, rdat, lat);
        check("R9 back to 16-bit", 32'(size8), 32'd0);
        bus_cycle(1'b1, 24'h012340, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R9 narrow write low byte only", 32'(rdat), 32'hA57E);

        // R11: no acknowledge without a pending request
        iack_cycle(ack, rdat);
        check("R11 iack without pending", 32'(ack), 32'd0);

        // R10: raise and read back the request
        bus_cycle(1'b0, 24'h012346, 2'b00, 16'h0001, 1'b1, ack, rdat, lat);
        check("R10 irq_n low", 32'(irq_n), 32'd0);
        bus_cycle(1'b1, 24'h012346, 2'b00, 16'h0, 1'b1, ack, rdat, lat);
        check("R10 pending readback", 32'(rdat), 32'h0001);

        // R11: interrupt acknowledge returns the vector and clears the request
        iack_cycle(ack, rdat);
        check("R11 iack ack", 32'(ack), 32'd1);
        check("R11 vector", 32'(rdat), {24'h0, VEC});
        check("R11 irq cleared", 32'(irq_n), 32'd1);

        // R10: clear by write
        bus_cycle(1'b0, 24'h012346, 2'b00, 16'h0001, 1'b1, ack, rdat, lat);
        bus_cycle(1'b0, 24'h012346, 2'b00, 16'h0000, 1'b1, ack, rdat, lat);
        check("R10 irq cleared by write", 32'(irq_n), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule